// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B. It passes data in either direction, either as it arrives or from a per-direction holding register. Each direction has its own storage register with its own capture clock. The A-side register samples bus A and the B-side register samples bus B. Capture happens on every rising edge of the register's clock, whatever the routing and enable inputs are. For each direction, a pick input chooses what the driven side carries: the live value from the opposite bus, or that direction's stored value.

The two driver enables have opposite polarity. The B-side drivers are enabled by an active-high input. The A-side drivers are enabled by an active-low input. Each port is brought out as separate input, output and output-enable vectors, so no tristate logic sits inside the block. A wrapper at chip or test level resolves them onto shared nets. With both picks set to live and both driver sets on, each bus is driven from the other. Once every outside source lets go of the buses, they keep their last values. The block has no reset, and the storage registers are undefined until they are first clocked.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising edge on `cap_ab_clk` loads the A-side register with `a_i` as it stands at that edge, whatever the pick and enable inputs are.
- R2: A rising edge on `cap_ba_clk` loads the B-side register with `b_i` as it stands at that edge, whatever the pick and enable inputs are.
- R3: With `pick_ab` = 0, `b_o` equals the live `a_i`. With `pick_ab` = 1, `b_o` equals the A-side register.
- R4: With `pick_ba` = 0, `a_o` equals the live `b_i`. With `pick_ba` = 1, `a_o` equals the B-side register.
- R5: `b_oe` is all ones when `drv_b_en` is 1 and all zeros when it is 0 (active high).
- R6: `a_oe` is all ones when `drv_a_en_n` is 0 and all zeros when it is 1 (active low). With `drv_b_en` = 0 and `drv_a_en_n` = 1, neither port drives.
- R7: The two registers are independent. Clocking both at the same edge loads both, and clocking only one leaves the other's stored value unchanged.
- R8: With both picks at 0, `drv_b_en` = 1 and `drv_a_en_n` = 0, each bus is driven with the value read from the other. After every outside driver is released, both resolved buses keep the last value that was placed on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_ab_clk | input | 1 | Rising edge loads the A-side register from bus A |
| cap_ba_clk | input | 1 | Rising edge loads the B-side register from bus B |
| pick_ab | input | 1 | Source for the B drivers: 0 live A, 1 stored A |
| pick_ba | input | 1 | Source for the A drivers: 0 live B, 1 stored B |
| drv_b_en | input | 1 | Active-high enable for the B-side drivers |
| drv_a_en_n | input | 1 | Active-low enable for the A-side drivers |
| a_i | input | W | Value read from bus A |
| a_o | output | W | Value offered to bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_i | input | W | Value read from bus B |
| b_o | output | W | Value offered to bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The bench builds the block with its default values: an 8-bit width, an active-high B-side enable and an active-low A-side enable. These defaults bring every pick and enable combination within reach, including the fully isolated state and the state where both ports drive. A resolving wrapper with a one-cycle keeper on each net closes the loop through the block. Because of that, the hold behaviour can be seen on the resolved buses after external drivers are handed from one side to the other and then released.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      PICK_LIVE = 1'b0,
      PICK_HELD = 1'b1
   } pick_e;

   localparam int unsigned XCVR_MAX_W = 1024;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int unsigned W = 8
) (
   input  logic         cap_clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W == 0) begin : g_bad_w
      $error("xcvr_store: W must be nonzero");
   end

   always_ff @(posedge cap_clk) begin
      q <= d;
   end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
   import xcvr_pkg::*;
#(
   parameter int unsigned W              = 8,
   parameter bit          EN_ACTIVE_HIGH = 1'b1
) (
   input  logic         pick,
   input  logic         en,
   input  logic [W-1:0] live,
   input  logic [W-1:0] held,
   output logic [W-1:0] dout,
   output logic [W-1:0] oe
);
   localparam logic [W-1:0] ALL_ON = {W{1'b1}};

   pick_e src;
   logic  en_on;

   assign src = pick_e'(pick);

   if (EN_ACTIVE_HIGH) begin : g_en_hi
      assign en_on = en;
   end else begin : g_en_lo
      assign en_on = ~en;
   end

   always_comb begin
      unique case (src)
         PICK_HELD: dout = held;
         default:   dout = live;
      endcase
   end

   assign oe = en_on ? ALL_ON : '0;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter bit          B_EN_HIGH  = 1'b1,
   parameter bit          A_EN_HIGH  = 1'b0
) (
   input  logic         cap_ab_clk,
   input  logic         cap_ba_clk,
   input  logic         pick_ab,
   input  logic         pick_ba,
   input  logic         drv_b_en,
   input  logic         drv_a_en_n,
   input  logic [W-1:0] a_i,
   output logic [W-1:0] a_o,
   output logic [W-1:0] a_oe,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] b_o,
   output logic [W-1:0] b_oe
);
   if (W == 0 || W > XCVR_MAX_W) begin : g_bad_w
      $error("regbus_xcvr: W out of range");
   end

   logic [W-1:0] hold_a;
   logic [W-1:0] hold_b;

   xcvr_store #(.W(W)) u_store_a (
      .cap_clk (cap_ab_clk),
      .d       (a_i),
      .q       (hold_a)
   );

   xcvr_store #(.W(W)) u_store_b (
      .cap_clk (cap_ba_clk),
      .d       (b_i),
      .q       (hold_b)
   );

   xcvr_route #(.W(W), .EN_ACTIVE_HIGH(B_EN_HIGH)) u_route_ab (
      .pick (pick_ab),
      .en   (drv_b_en),
      .live (a_i),
      .held (hold_a),
      .dout (b_o),
      .oe   (b_oe)
   );

   xcvr_route #(.W(W), .EN_ACTIVE_HIGH(A_EN_HIGH)) u_route_ba (
      .pick (pick_ba),
      .en   (drv_a_en_n),
      .live (b_i),
      .held (hold_b),
      .dout (a_o),
      .oe   (a_oe)
   );
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int unsigned W = 8
) (
   input  logic         cap_ab_clk,
   input  logic         cap_ba_clk,
   input  logic         pick_ab,
   input  logic         pick_ba,
   input  logic         drv_b_en,
   input  logic         drv_a_en_n,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] a_o,
   input  logic [W-1:0] a_oe,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] b_o,
   input  logic [W-1:0] b_oe,
   input  logic [W-1:0] stored_a,
   input  logic [W-1:0] stored_b
);
   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic [W-1:0] shadow_a;
   logic [W-1:0] shadow_b;
   logic         have_a = 1'b0;
   logic         have_b = 1'b0;

   always_ff @(posedge cap_ab_clk) begin
      shadow_a <= a_i;
      have_a   <= 1'b1;
   end

   always_ff @(posedge cap_ba_clk) begin
      shadow_b <= b_i;
      have_b   <= 1'b1;
   end

   // R1: the stored A value is the bus A value seen at the previous A capture edge
   a_r1_cap_a: assert property (@(posedge cap_ab_clk) have_a |-> stored_a == shadow_a);
   // R2: the same for the B side
   a_r2_cap_b: assert property (@(posedge cap_ba_clk) have_b |-> stored_b == shadow_b);
   // R3
   a_r3_live_ab:   assert property (@(posedge cap_ab_clk) !pick_ab |-> b_o == a_i);
   a_r3_stored_ab: assert property (@(posedge cap_ba_clk) (pick_ab && have_a) |-> b_o == shadow_a);
   // R4
   a_r4_live_ba:   assert property (@(posedge cap_ba_clk) !pick_ba |-> a_o == b_i);
   a_r4_stored_ba: assert property (@(posedge cap_ab_clk) (pick_ba && have_b) |-> a_o == shadow_b);
   // R5
   a_r5_oe_b: assert property (@(posedge cap_ab_clk) (drv_b_en ? (b_oe == ONES) : (b_oe == '0)));
   // R6
   a_r6_oe_a: assert property (@(posedge cap_ba_clk) (drv_a_en_n ? (a_oe == '0) : (a_oe == ONES)));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
   .cap_ab_clk (cap_ab_clk),
   .cap_ba_clk (cap_ba_clk),
   .pick_ab    (pick_ab),
   .pick_ba    (pick_ba),
   .drv_b_en   (drv_b_en),
   .drv_a_en_n (drv_a_en_n),
   .a_i        (a_i),
   .a_o        (a_o),
   .a_oe       (a_oe),
   .b_i        (b_i),
   .b_o        (b_o),
   .b_oe       (b_oe),
   .stored_a   (hold_a),
   .stored_b   (hold_b)
);

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
   localparam int unsigned W = 8;

   typedef struct packed {
      logic [W-1:0] ao;
      logic [W-1:0] aoe;
      logic [W-1:0] bo;
      logic [W-1:0] boe;
   } exp_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         cap_ab_clk = 1'b0;
   logic         cap_ba_clk = 1'b0;
   logic         pick_ab = 1'b0;
   logic         pick_ba = 1'b0;
   logic         drv_b_en = 1'b0;
   logic         drv_a_en_n = 1'b1;
   logic [W-1:0] a_i, a_o, a_oe, b_i, b_o, b_oe;

   // resolving wrapper: outside drivers win, otherwise a one-cycle keeper
   logic         ext_a_on = 1'b1;
   logic         ext_b_on = 1'b1;
   logic [W-1:0] ext_a_val = '0;
   logic [W-1:0] ext_b_val = '0;
   logic [W-1:0] keep_a = '0;
   logic [W-1:0] keep_b = '0;

   assign a_i = ext_a_on ? ext_a_val : keep_a;
   assign b_i = ext_b_on ? ext_b_val : keep_b;

   always @(posedge clk) begin
      keep_a <= ext_a_on ? ext_a_val : (a_oe[0] ? a_o : keep_a);
      keep_b <= ext_b_on ? ext_b_val : (b_oe[0] ? b_o : keep_b);
   end

   regbus_xcvr #(.W(W)) u_dut (
      .cap_ab_clk (cap_ab_clk),
      .cap_ba_clk (cap_ba_clk),
      .pick_ab    (pick_ab),
      .pick_ba    (pick_ba),
      .drv_b_en   (drv_b_en),
      .drv_a_en_n (drv_a_en_n),
      .a_i        (a_i),
      .a_o        (a_o),
      .a_oe       (a_oe),
      .b_i        (b_i),
      .b_o        (b_o),
      .b_oe       (b_oe)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   exp_t  exp_q[$];
   string tag_q[$];

   logic [W-1:0] m_reg_a, m_reg_b;

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // driver: sets inputs, pulses the requested capture clocks, queues expected outputs
   task automatic apply(input string tag, input logic s_ab, input logic s_ba,
                        input logic en_b, input logic en_a_n,
                        input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic p_ab, input logic p_ba);
      exp_t e;
      @(negedge clk);
      pick_ab = s_ab; pick_ba = s_ba;
      drv_b_en = en_b; drv_a_en_n = en_a_n;
      ext_a_on = 1'b1; ext_b_on = 1'b1;
      ext_a_val = av; ext_b_val = bv;
      #1;
      cap_ab_clk = p_ab;
      cap_ba_clk = p_ba;
      if (p_ab) m_reg_a = av;
      if (p_ba) m_reg_b = bv;
      e.bo  = s_ab ? m_reg_a : av;
      e.ao  = s_ba ? m_reg_b : bv;
      e.boe = en_b ? '1 : '0;
      e.aoe = en_a_n ? '0 : '1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #2;
      cap_ab_clk = 1'b0;
      cap_ba_clk = 1'b0;
   endtask

   // monitor
   always @(posedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk({t, " b_o"},  b_o,  e.bo);
         chk({t, " a_o"},  a_o,  e.ao);
         chk({t, " b_oe"}, b_oe, e.boe);
         chk({t, " a_oe"}, a_oe, e.aoe);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R6 isolation plus R7 simultaneous capture of both registers
      apply("R6/R7 isolated, both captured", 1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22, 1'b1, 1'b1);
      // R3/R4 stored values shown while live data changes
      apply("R3/R4 stored", 1'b1, 1'b1, 1'b1, 1'b0, 8'h33, 8'h44, 1'b0, 1'b0);
      // R3/R5 real-time A to B
      apply("R3/R5 live A to B", 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h66, 1'b0, 1'b0);
      // R4/R6 real-time B to A
      apply("R4/R6 live B to A", 1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 8'hA5, 1'b0, 1'b0);
      // R1/R7 only the A register is clocked while isolated
      apply("R1/R7 A only", 1'b1, 1'b1, 1'b0, 1'b1, 8'h77, 8'hEE, 1'b1, 1'b0);
      apply("R1/R7 A only, view", 1'b1, 1'b1, 1'b1, 1'b0, 8'h01, 8'h02, 1'b0, 1'b0);
      // R2/R7 only the B register is clocked
      apply("R2/R7 B only", 1'b1, 1'b1, 1'b0, 1'b1, 8'hC1, 8'h88, 1'b0, 1'b1);
      // R1/R2 capture while live and enabled, then view stored
      apply("R1/R2 capture while live", 1'b0, 1'b0, 1'b1, 1'b0, 8'hB4, 8'h4B, 1'b1, 1'b1);
      apply("R1/R2 capture view", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
      // every pick/enable combination, R3 R4 R5 R6
      for (int i = 0; i < 16; i++) begin
         apply("R3/R4/R5/R6 sweep", i[0], i[1], i[2], i[3],
               8'(i * 37 + 5), 8'(i * 91 + 3), (i % 3) == 0, (i % 2) == 1);
      end
      @(negedge clk);
      @(negedge clk);

      // R8 bus hold through the wrapper
      pick_ab = 1'b0; pick_ba = 1'b0; drv_b_en = 1'b1; drv_a_en_n = 1'b0;
      ext_a_on = 1'b1; ext_a_val = 8'h3C; ext_b_on = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 B follows A", b_i, 8'h3C);
      ext_a_on = 1'b0; ext_b_on = 1'b1; ext_b_val = 8'hC3;
      repeat (3) @(negedge clk);
      chk("R8 A follows B", a_i, 8'hC3);
      ext_b_on = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8 A held", a_i, 8'hC3);
      chk("R8 B held", b_i, 8'hC3);
      repeat (5) @(negedge clk);
      chk("R8 A still held", a_i, 8'hC3);
      chk("R8 B still held", b_i, 8'hC3);

      finish_run();
   end
endmodule